// File: doc/BRIEF.md
# Serial SAR Converter Readout Master

This block sits on the host side of a 12-bit serial successive-approximation converter. It starts conversions, generates the serial clock, and collects each result. An active-low conversion strobe opens every frame. A serial clock, divided down from the system clock, then runs for exactly sixteen periods while the converter shifts its answer out on one data line. The master samples that line on the edge selected by a two-bit polarity/phase mode. It drops the leading zero bits and assembles the twelve result bits, most significant first. The sample is then presented as a one-cycle valid pulse with a held data word. A negative flag marks the sample when the frame was taken in two's-complement (bipolar) interpretation.

Conversions run either one at a time, started by a `start_i` pulse, or back to back while `cont_i` is high. In back-to-back operation the strobe is released part way through the frame, so the converter keeps driving its output and the next frame follows without a gap on the bus. The control is a four-state machine. IDLE holds the strobe high and parks the clock at the selected idle level. LEAD holds the strobe low for one half period before the first clock edge. CLOCK issues the thirty-two clock edges. TAIL holds the strobe high for one half period. The transitions are: IDLE to LEAD on `start_i`; LEAD to CLOCK after one half period; CLOCK to TAIL after the thirty-second half period; TAIL to LEAD when `cont_i` is high, otherwise TAIL to IDLE.

Top module: `sar_readout_master`

## Requirements
- R1: One serial clock half period lasts HALF system clocks, where HALF is the larger of `HALF_FLOOR` and ceil(`SYS_HZ` / (2 × `SCLK_MAX_HZ`)). This keeps the serial clock at or below `SCLK_MAX_HZ`, which is 28.8 MHz by default.
- R2: When `start_i` is high at a clock edge in IDLE, the strobe `cnv_n_o` falls and `busy_o` rises at that edge. The serial clock stays at its idle level for one further half period before its first edge.
- R3: Every frame issues exactly 32 serial clock edges, or 16 full periods. Each half period alternates the level, starting away from the idle level, and the clock ends back at the idle level.
- R4: `mode_i[1]` is the clock polarity (idle level) and `mode_i[0]` is the phase. Data is captured on rising edges when the two bits are equal (modes 0 and 3) and on falling edges otherwise (modes 1 and 2). The mode is latched when the frame starts.
- R5: The converter presents three zero bits and then twelve data bits MSB first. After rising edge n it holds frame bit n, with bit 0 shown from the strobe fall. The master keeps only the twelve data bits: rising-edge modes capture at rising edges 4 to 15, and falling-edge modes capture at the falling edges that follow rising edges 3 to 14.
- R6: `valid_o` is high for exactly one cycle, the cycle after the edge that captured the 12th data bit. `data_o` changes only together with that pulse and otherwise holds the last result.
- R7: `neg_o` equals the `bipolar_i` value latched at frame start ANDed with data bit 11. It is updated with `data_o`, which is never altered by the interpretation.
- R8: With `cont_i` low, the strobe stays low through the 16th falling clock edge and rises when the last half period ends. `busy_o` then falls one half period later, returning to IDLE.
- R9: With `cont_i` high, the strobe rises at the falling clock edge that follows the 14th rising edge. The next frame's strobe fall follows automatically after TAIL, with no new `start_i`.
- R10: While `busy_o` is high, `start_i` has no effect. In IDLE the strobe stays high and the serial clock follows the idle level selected by `mode_i[1]`.
- R11: After reset `cnv_n_o` is 1, `busy_o`, `valid_o`, `neg_o` and `sclk_o` are 0, and `data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin one conversion when idle |
| cont_i | input | 1 | Chain frames back to back while high |
| mode_i | input | 2 | {polarity, phase} of the serial clock |
| bipolar_i | input | 1 | Interpret the result as two's complement |
| adc_sdo_i | input | 1 | Serial data from the converter |
| cnv_n_o | output | 1 | Active-low conversion strobe |
| sclk_o | output | 1 | Serial clock to the converter |
| busy_o | output | 1 | High from strobe fall until the frame ends |
| valid_o | output | 1 | One-cycle result strobe |
| data_o | output | 12 | Last captured result |
| neg_o | output | 1 | Result is negative in bipolar interpretation |

## Verification
The bench builds the block with a 200 MHz system rate, the default 28.8 MHz serial limit and a floor of 2. The rate ceiling therefore sets the half period at four cycles, and the floor is not the value in force. At that setting all four clock modes can be run in sequence, each against a converter model that changes its line on rising edges. This shows that the capture windows for rising and falling edges land on the right bits. Back-to-back frames are run under both idle polarities, so the strobe release after the 14th rising edge is seen at both of its possible half-period positions.

// File: rtl/rdm_pkg.sv
package rdm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_CLOCK = 2'd2,
        ST_TAIL  = 2'd3
    } rdm_state_e;

endpackage

// File: rtl/rdm_half_timer.sv
module rdm_half_timer #(
    parameter int unsigned HALF = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rdm_capture.sv
module rdm_capture #(
    parameter int unsigned DATA_W = 12,
    parameter int unsigned ZEROS  = 3,
    parameter int unsigned RCW    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_clr,
    input  logic              edge_en,
    input  logic              edge_rise,
    input  logic [RCW-1:0]    rc_after,
    input  logic              rise_mode,
    input  logic              sdo,
    input  logic              bip,
    output logic              valid,
    output logic [DATA_W-1:0] data,
    output logic              neg
);
    localparam int unsigned NBW = $clog2(DATA_W + 1);
    // rising-edge modes take bit n at rising edge n+1
    localparam logic [RCW-1:0] RISE_LO = RCW'(ZEROS + 1);
    localparam logic [RCW-1:0] RISE_HI = RCW'(ZEROS + DATA_W);
    // falling-edge modes take bit n at the falling edge after rising edge n
    localparam logic [RCW-1:0] FALL_LO = RCW'(ZEROS);
    localparam logic [RCW-1:0] FALL_HI = RCW'(ZEROS + DATA_W - 1);
    localparam logic [NBW-1:0] LAST_BIT = NBW'(DATA_W - 1);

    logic [DATA_W-2:0] sh_q;
    logic [NBW-1:0]    nb_q;
    logic              in_win;
    logic              cap;

    always_comb begin
        if (rise_mode) begin
            in_win = edge_rise && (rc_after >= RISE_LO) && (rc_after <= RISE_HI);
        end else begin
            in_win = !edge_rise && (rc_after >= FALL_LO) && (rc_after <= FALL_HI);
        end
    end

    assign cap = edge_en && in_win;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            nb_q  <= '0;
            valid <= 1'b0;
            data  <= '0;
            neg   <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (frame_clr) begin
                nb_q <= '0;
            end else if (cap) begin
                sh_q <= {sh_q[DATA_W-3:0], sdo};
                if (nb_q == LAST_BIT) begin
                    nb_q  <= '0;
                    data  <= {sh_q, sdo};
                    neg   <= bip & sh_q[DATA_W-2];
                    valid <= 1'b1;
                end else begin
                    nb_q <= nb_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sar_readout_master.sv
module sar_readout_master
    import rdm_pkg::*;
#(
    parameter int unsigned SYS_HZ      = 200_000_000,
    parameter int unsigned SCLK_MAX_HZ = 28_800_000,
    parameter int unsigned HALF_FLOOR  = 1,
    parameter int unsigned DATA_W      = 12,
    parameter int unsigned ZEROS       = 3,
    parameter int unsigned FRAME       = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              cont_i,
    input  logic [1:0]        mode_i,
    input  logic              bipolar_i,
    input  logic              adc_sdo_i,
    output logic              cnv_n_o,
    output logic              sclk_o,
    output logic              busy_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o,
    output logic              neg_o
);
    localparam int unsigned HALF_RATE = (SYS_HZ + 2 * SCLK_MAX_HZ - 1) / (2 * SCLK_MAX_HZ);
    localparam int unsigned HALF      = (HALF_RATE > HALF_FLOOR) ? HALF_RATE : HALF_FLOOR;
    localparam int unsigned HPW       = $clog2(2 * FRAME);
    localparam int unsigned RCW       = $clog2(FRAME + 1);
    localparam logic [HPW-1:0] LAST_HP  = HPW'(2 * FRAME - 1);
    localparam logic [RCW-1:0] REL_RISE = RCW'(FRAME - 2);

    rdm_state_e     state_q, state_d;
    logic [HPW-1:0] hp_q;
    logic [RCW-1:0] rise_cnt_q;
    logic [RCW-1:0] rc_after;
    logic [1:0]     mode_q;
    logic           bip_q;
    logic           sclk_q;
    logic           cnv_n_q;
    logic           tick;
    logic           edge_en;
    logic           edge_rise;
    logic           frame_clr;

    rdm_half_timer #(.HALF(HALF)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (state_q != ST_IDLE),
        .tick (tick)
    );

    assign edge_en   = tick && ((state_q == ST_LEAD) ||
                                ((state_q == ST_CLOCK) && (hp_q != LAST_HP)));
    assign edge_rise = ~sclk_q;
    assign rc_after  = rise_cnt_q + {{(RCW-1){1'b0}}, edge_rise};
    assign frame_clr = ((state_q == ST_IDLE) && start_i) ||
                       ((state_q == ST_TAIL) && tick && cont_i);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_LEAD;
            ST_LEAD:  if (tick) state_d = ST_CLOCK;
            ST_CLOCK: if (tick && (hp_q == LAST_HP)) state_d = ST_TAIL;
            ST_TAIL:  if (tick) state_d = cont_i ? ST_LEAD : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs and frame registers
    always_ff @(posedge clk) begin
        if (rst) begin
            hp_q       <= '0;
            rise_cnt_q <= '0;
            mode_q     <= 2'b00;
            bip_q      <= 1'b0;
            sclk_q     <= 1'b0;
            cnv_n_q    <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    mode_q     <= mode_i;
                    bip_q      <= bipolar_i;
                    sclk_q     <= mode_i[1];
                    rise_cnt_q <= '0;
                    if (start_i) cnv_n_q <= 1'b0;
                end
                ST_LEAD: begin
                    if (tick) begin
                        hp_q       <= '0;
                        sclk_q     <= ~sclk_q;
                        rise_cnt_q <= rc_after;
                    end
                end
                ST_CLOCK: begin
                    if (tick) begin
                        if (hp_q != LAST_HP) begin
                            hp_q       <= hp_q + 1'b1;
                            sclk_q     <= ~sclk_q;
                            rise_cnt_q <= rc_after;
                            if (cont_i && !edge_rise && (rise_cnt_q == REL_RISE)) begin
                                cnv_n_q <= 1'b1;
                            end
                        end else begin
                            cnv_n_q <= 1'b1;
                        end
                    end
                end
                ST_TAIL: begin
                    if (tick && cont_i) begin
                        cnv_n_q    <= 1'b0;
                        rise_cnt_q <= '0;
                    end
                end
                default: begin
                    cnv_n_q <= 1'b1;
                end
            endcase
        end
    end

    rdm_capture #(.DATA_W(DATA_W), .ZEROS(ZEROS), .RCW(RCW)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .frame_clr (frame_clr),
        .edge_en   (edge_en),
        .edge_rise (edge_rise),
        .rc_after  (rc_after),
        .rise_mode (mode_q[1] == mode_q[0]),
        .sdo       (adc_sdo_i),
        .bip       (bip_q),
        .valid     (valid_o),
        .data      (data_o),
        .neg       (neg_o)
    );

    assign cnv_n_o = cnv_n_q;
    assign sclk_o  = sclk_q;
    assign busy_o  = (state_q != ST_IDLE);
endmodule

// File: rtl/rdm_checker.sv
module rdm_checker #(
    parameter int unsigned DATA_W = 12,
    parameter int unsigned FRAME  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cnv_n,
    input logic              sclk,
    input logic              busy,
    input logic              valid,
    input logic [DATA_W-1:0] data,
    input logic              neg
);
    localparam int unsigned EW = $clog2(2 * FRAME + 2);
    localparam logic [EW-1:0] EDGES = EW'(2 * FRAME);

    logic [EW-1:0] edges_q;
    logic          sclk_prev_q;
    logic          cnv_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            edges_q     <= '0;
            sclk_prev_q <= 1'b0;
            cnv_prev_q  <= 1'b1;
        end else begin
            sclk_prev_q <= sclk;
            cnv_prev_q  <= cnv_n;
            if (!cnv_n && cnv_prev_q) begin
                edges_q <= '0;
            end else if (busy && (sclk != sclk_prev_q)) begin
                edges_q <= edges_q + 1'b1;
            end
        end
    end

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R6
    valid_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> busy);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid |-> $stable(data));

    // R2
    busy_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !cnv_n);

    // R2
    lead_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cnv_n) |-> $stable(sclk));

    // R10
    idle_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cnv_n);

    // R3
    edge_count_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (edges_q == EDGES));

    // R7
    neg_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && neg) |-> data[DATA_W-1]);
endmodule

bind sar_readout_master rdm_checker #(.DATA_W(DATA_W), .FRAME(FRAME)) u_rdm_chk (
    .clk   (clk),
    .rst   (rst),
    .cnv_n (cnv_n_o),
    .sclk  (sclk_o),
    .busy  (busy_o),
    .valid (valid_o),
    .data  (data_o),
    .neg   (neg_o)
);

// File: tb/sar_readout_master_tb_top.sv
`timescale 1ns/1ps
module sar_readout_master_tb_top;
    // 200e6 / (2 * 28.8e6) = 3.47, rounded up to 4; floor of 2 is lower
    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        cont = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic        bip = 1'b0;
    logic        sdo = 1'b0;
    logic        cnv_n, sclk, busy, valid, neg;
    logic [11:0] data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [11:0] code_tab [0:15];

    always #2.5 clk = ~clk;

    sar_readout_master #(.HALF_FLOOR(2)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start),
        .cont_i    (cont),
        .mode_i    (mode),
        .bipolar_i (bip),
        .adc_sdo_i (sdo),
        .cnv_n_o   (cnv_n),
        .sclk_o    (sclk),
        .busy_o    (busy),
        .valid_o   (valid),
        .data_o    (data),
        .neg_o     (neg)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // converter model: frame bit 0 at strobe fall, bit n after rising edge n
    int cf = 0;
    int ridx = 0;
    logic [11:0] ccode = '0;

    function automatic logic fbit(input int i, input logic [11:0] c);
        if (i >= 3 && i <= 14) return c[14 - i];
        return 1'b0;
    endfunction

    always @(negedge cnv_n) begin
        ridx = 0;
        ccode = code_tab[cf];
        cf++;
        sdo = 1'b0;
    end

    always @(posedge sclk) begin
        ridx++;
        #1 sdo = fbit(ridx, ccode);
    end

    // cycle reference model
    int  k = 0;
    bit  act = 0, rel = 0;
    bit  e_cpol = 0, e_cpha = 0, e_bip = 0;
    int  rf = 0;
    int  nval = 0;
    logic [11:0] exp_data = '0;
    bit exp_neg = 0;

    always @(posedge clk) begin
        if (rst) begin
            act = 0; k = 0; rel = 0; e_cpol = 0; e_cpha = 0; e_bip = 0; rf = 0;
        end else if (!act) begin
            e_cpol = mode[1];
            e_cpha = mode[0];
            e_bip  = bip;
            if (start) begin
                act = 1; k = 0; rel = 0;
            end
        end else begin
            k++;
            if (k == H * (28 + int'(e_cpol)) && cont) rel = 1;
            if (k == 34 * H) begin
                rf++;
                if (cont) begin
                    k = 0; rel = 0;
                end else begin
                    act = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit e_sclk, e_cnv, e_valid;
            int hl;
            hl = 27 + int'(e_cpol) + ((e_cpol == e_cpha) ? 1 : 0);
            if (!act) begin
                e_sclk = e_cpol; e_cnv = 1;
            end else if (k < H) begin
                e_sclk = e_cpol; e_cnv = 0;
            end else if (k < 33 * H) begin
                e_sclk = ((((k - H) / H) % 2) == 0) ? !e_cpol : e_cpol;
                e_cnv  = rel;
            end else begin
                e_sclk = e_cpol; e_cnv = 1;
            end
            e_valid = act && (k == H * (hl + 1));
            if (e_valid) begin
                exp_data = code_tab[rf];
                exp_neg  = e_bip & code_tab[rf][11];
            end
            if (valid) nval++;
            chk(sclk == e_sclk, "R3", "sclk", sclk, e_sclk);
            chk(cnv_n == e_cnv, "R8/R9", "strobe", cnv_n, e_cnv);
            chk(busy == act, "R2", "busy", busy, act);
            chk(valid == e_valid, "R6", "valid", valid, e_valid);
            chk(data == exp_data, "R4/R5", "data", data, exp_data);
            chk(neg == exp_neg, "R7", "neg", neg, exp_neg);
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        code_tab[0] = 12'hA5C; code_tab[1] = 12'hFFF; code_tab[2] = 12'h000;
        code_tab[3] = 12'h801; code_tab[4] = 12'h123; code_tab[5] = 12'h7FF;
        code_tab[6] = 12'h800; code_tab[7] = 12'h001; code_tab[8] = 12'h3C3;
        code_tab[9] = 12'hC3C;
        for (int i = 10; i < 16; i++) code_tab[i] = 12'h555;

        repeat (4) @(negedge clk);
        // R11 reset state
        chk(cnv_n == 1'b1, "R11", "strobe", cnv_n, 1);
        chk(busy == 1'b0 && valid == 1'b0, "R11", "busy/valid", {busy, valid}, 0);
        chk(sclk == 1'b0 && neg == 1'b0, "R11", "sclk/neg", {sclk, neg}, 0);
        chk(data == 12'h000, "R11", "data", data, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R4 R5 single frames in all four modes
        for (int m = 0; m < 4; m++) begin
            mode = 2'(m);
            bip  = m[0];
            repeat (2) @(negedge clk);
            pulse_start();
            if (m == 2) begin
                // R10 start while busy is ignored
                repeat (40) @(negedge clk);
                start = 1'b1;
                @(negedge clk) start = 1'b0;
            end
            wait_idle();
            chk(cnv_n == 1'b1, "R8", "strobe after single", cnv_n, 1);
        end
        chk(nval == 4, "R6", "valid count", nval, 4);

        // R10 idle level follows polarity
        mode = 2'b10;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b1, "R10", "idle sclk high", sclk, 1);
        mode = 2'b00;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b0, "R10", "idle sclk low", sclk, 0);

        // R1 half period length
        begin
            int cyc;
            cyc = 0;
            pulse_start();
            while (sclk == 1'b0) @(negedge clk);
            while (sclk == 1'b1) begin
                @(negedge clk);
                cyc++;
            end
            chk(cyc == H, "R1", "half period", cyc, H);
            wait_idle();
        end

        // R9 continuous, polarity 1
        mode = 2'b11; bip = 1'b1; cont = 1'b1;
        repeat (2) @(negedge clk);
        begin
            int target;
            target = nval + 3;
            pulse_start();
            while (nval < target) @(negedge clk);
            cont = 1'b0;
            wait_idle();
            chk(nval == target, "R9", "chained results", nval, target);
        end

        // R9 continuous, polarity 0
        mode = 2'b01; bip = 1'b0; cont = 1'b1;
        repeat (2) @(negedge clk);
        begin
            int target;
            target = nval + 2;
            pulse_start();
            while (nval < target) @(negedge clk);
            cont = 1'b0;
            wait_idle();
            chk(nval == target, "R9", "chained results", nval, target);
        end
        chk(cf == 10, "R9", "frames started", cf, 10);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule